// File: doc/BRIEF.md
# Windowed Per-Key Event Threshold Detector

The block watches a stream of event strobes, each tagged with a source key. It raises a one-cycle fire pulse, carrying that key, only when a set number of events from the same key arrive within a set window of clock ticks. A downstream action stage, such as a packet drop, uses the pulse. With a threshold of one, every event fires at once. With a larger threshold, the earlier events in a run are absorbed without any pulse.

State lives in a direct-mapped table indexed by the low key bits. Each slot holds the full key tag, a running count and an age counter that starts when a run begins. An event that lands on an empty slot, on a slot owned by another key, or on a slot whose window has run out starts a new run with count one. When the threshold is reached, the slot is emptied, so the next event from that key starts a new run.

Top module: `evt_thr_detect`

## Requirements
- R1: After the active-low asynchronous reset `rst_ni` is released, `fire_o` is 0 and every table slot is empty, so no earlier partial run can contribute to a later fire.
- R2: With `thresh_i` equal to 1, or 0 (which is treated as 1), every accepted event produces `fire_o`=1 in the cycle after the clock edge that samples `evt_i`, and `fire_key_o` then equals the sampled key.
- R3: With `thresh_i`=N>1, the events numbered 1 to N-1 of a run produce no fire, and event N produces a fire one cycle after it is sampled.
- R4: Call the edge of a run's first event t0. An event from the same key at edge t0+d joins the run only when d < `win_len_i`. When d >= `win_len_i`, the event starts a new run with count 1.
- R5: Keys that map to different slots (key bits [3:0] differ) are counted independently, and their events never add together.
- R6: A key whose bits [3:0] match the slot of a resident key with a different full tag replaces that entry and starts with count 1.
- R7: After a fire, the key's slot is empty, and the next event from that key starts a new run with count 1.
- R8: `fire_o` is asserted only in the cycle directly after an edge at which `evt_i` was 1, and it is never held longer than that one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Event strobe, one event per cycle when high |
| key_i | input | KEY_W | Source key of the event; bits [IDX_W-1:0] select the slot |
| thresh_i | input | CNT_W | Events per run needed to fire; 0 behaves as 1 |
| win_len_i | input | WIN_W | Window length in clock ticks |
| fire_o | output | 1 | One-cycle fire pulse |
| fire_key_o | output | KEY_W | Key that caused the fire |

## Verification
Directed sequences drive a single key at thresholds 0, 1 and 3, separating immediate firing from a delayed fire on the Nth event. Window runs place the second event one tick inside and exactly at the window edge, which separates a joined run from a restarted one. Interleaved keys on different slots show that counts stay separate, and two keys sharing a slot show the replacement behaviour. Constrained-random traffic then mixes colliding keys, idle gaps and changing threshold and window settings, and is compared each cycle against a bench model that tracks run start times rather than per-slot ages.

// File: rtl/evt_thr_pkg.sv
`timescale 1ns/1ps
package evt_thr_pkg;
  parameter int unsigned DEF_KEY_W = 8;
  parameter int unsigned DEF_IDX_W = 4;
  parameter int unsigned DEF_CNT_W = 8;
  parameter int unsigned DEF_WIN_W = 16;

  typedef enum logic [1:0] {
    VERD_IDLE  = 2'd0,
    VERD_FRESH = 2'd1,
    VERD_ACCUM = 2'd2,
    VERD_FIRE  = 2'd3
  } verdict_e;
endpackage

// File: rtl/evt_thr_slot.sv
`timescale 1ns/1ps
module evt_thr_slot #(
  parameter int unsigned KEY_W = 8,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             fresh_i,
  input  logic [KEY_W-1:0] tag_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             vld_o,
  output logic [KEY_W-1:0] tag_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [WIN_W-1:0] age_o
);
  localparam logic [WIN_W-1:0] AGE_MAX = '1;

  logic [WIN_W-1:0] age_inc;
  assign age_inc = (age_o == AGE_MAX) ? age_o : age_o + WIN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      tag_o <= '0;
      cnt_o <= '0;
      age_o <= '0;
    end else if (clr_i) begin
      vld_o <= 1'b0;
      cnt_o <= '0;
      age_o <= '0;
    end else if (set_i) begin
      vld_o <= 1'b1;
      tag_o <= tag_i;
      cnt_o <= cnt_i;
      // age 1 at the edge after the start: an event d edges later reads d
      age_o <= fresh_i ? WIN_W'(1) : age_inc;
    end else if (vld_o) begin
      age_o <= age_inc;
    end
  end

  a_r7_empty_after_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!vld_o && cnt_o == '0));

  a_r3_live_cnt_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (cnt_o != '0));

  a_r4_age_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !set_i && !clr_i && age_o != AGE_MAX) |=> (age_o == $past(age_o) + WIN_W'(1)));

  a_r4_fresh_age_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i && fresh_i) |=> (vld_o && age_o == WIN_W'(1)));
endmodule

// File: rtl/evt_thr_table.sv
`timescale 1ns/1ps
module evt_thr_table #(
  parameter int unsigned KEY_W = 8,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             fresh_i,
  input  logic [KEY_W-1:0] tag_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             rd_vld_o,
  output logic [KEY_W-1:0] rd_tag_o,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic [WIN_W-1:0] rd_age_o
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic             vld_q [ENTRIES];
  logic [KEY_W-1:0] tag_q [ENTRIES];
  logic [CNT_W-1:0] cnt_q [ENTRIES];
  logic [WIN_W-1:0] age_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = (idx_i == IDX_W'(g));
    evt_thr_slot #(
      .KEY_W(KEY_W), .CNT_W(CNT_W), .WIN_W(WIN_W)
    ) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_i && sel),
      .clr_i  (clr_i && sel),
      .fresh_i(fresh_i),
      .tag_i  (tag_i),
      .cnt_i  (cnt_i),
      .vld_o  (vld_q[g]),
      .tag_o  (tag_q[g]),
      .cnt_o  (cnt_q[g]),
      .age_o  (age_q[g])
    );
  end

  assign rd_vld_o = vld_q[idx_i];
  assign rd_tag_o = tag_q[idx_i];
  assign rd_cnt_o = cnt_q[idx_i];
  assign rd_age_o = age_q[idx_i];

  a_r5_one_slot_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && clr_i));
endmodule

// File: rtl/evt_thr_judge.sv
`timescale 1ns/1ps
module evt_thr_judge
  import evt_thr_pkg::*;
#(
  parameter int unsigned KEY_W = 8,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned WIN_W = 16
) (
  input  logic             evt_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic             vld_i,
  input  logic [KEY_W-1:0] tag_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [WIN_W-1:0] age_i,
  output verdict_e         verdict_o,
  output logic             fresh_o,
  output logic [CNT_W-1:0] nxt_cnt_o
);
  logic [CNT_W-1:0] thr_eff;
  logic             expired;

  assign thr_eff   = (thresh_i == '0) ? CNT_W'(1) : thresh_i;
  assign expired   = (age_i >= win_len_i);
  assign fresh_o   = !vld_i || (tag_i != key_i) || expired;
  assign nxt_cnt_o = fresh_o ? CNT_W'(1) : cnt_i + CNT_W'(1);

  always_comb begin
    if (!evt_i)                  verdict_o = VERD_IDLE;
    else if (nxt_cnt_o >= thr_eff) verdict_o = VERD_FIRE;
    else if (fresh_o)            verdict_o = VERD_FRESH;
    else                         verdict_o = VERD_ACCUM;
  end
endmodule

// File: rtl/evt_thr_detect.sv
`timescale 1ns/1ps
module evt_thr_detect
  import evt_thr_pkg::*;
#(
  parameter int unsigned KEY_W = DEF_KEY_W,
  parameter int unsigned IDX_W = DEF_IDX_W,
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned WIN_W = DEF_WIN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             fire_o,
  output logic [KEY_W-1:0] fire_key_o
);
  logic [IDX_W-1:0] idx;
  logic             rd_vld;
  logic [KEY_W-1:0] rd_tag;
  logic [CNT_W-1:0] rd_cnt;
  logic [WIN_W-1:0] rd_age;
  verdict_e         verdict;
  logic             fresh;
  logic [CNT_W-1:0] nxt_cnt;
  logic             do_set;
  logic             do_clr;

  assign idx = key_i[IDX_W-1:0];

  evt_thr_judge #(
    .KEY_W(KEY_W), .CNT_W(CNT_W), .WIN_W(WIN_W)
  ) u_judge (
    .evt_i    (evt_i),
    .key_i    (key_i),
    .thresh_i (thresh_i),
    .win_len_i(win_len_i),
    .vld_i    (rd_vld),
    .tag_i    (rd_tag),
    .cnt_i    (rd_cnt),
    .age_i    (rd_age),
    .verdict_o(verdict),
    .fresh_o  (fresh),
    .nxt_cnt_o(nxt_cnt)
  );

  assign do_clr = (verdict == VERD_FIRE);
  assign do_set = (verdict == VERD_FRESH) || (verdict == VERD_ACCUM);

  evt_thr_table #(
    .KEY_W(KEY_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .WIN_W(WIN_W)
  ) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (idx),
    .set_i   (do_set),
    .clr_i   (do_clr),
    .fresh_i (fresh),
    .tag_i   (key_i),
    .cnt_i   (nxt_cnt),
    .rd_vld_o(rd_vld),
    .rd_tag_o(rd_tag),
    .rd_cnt_o(rd_cnt),
    .rd_age_o(rd_age)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fire_o     <= 1'b0;
      fire_key_o <= '0;
    end else begin
      fire_o <= do_clr;
      if (do_clr) fire_key_o <= key_i;
    end
  end

  a_r8_fire_needs_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(evt_i));

  a_r2_unit_thresh_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && thresh_i <= CNT_W'(1)) |=> fire_o);

  a_r2_key_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (fire_key_o == $past(key_i)));

  a_r3_no_fire_while_absorbing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && rd_vld && rd_tag == key_i && rd_age < win_len_i
     && (rd_cnt + CNT_W'(1)) < thresh_i) |=> !fire_o);
endmodule

// File: tb/evt_thr_detect_tb_top.sv
`timescale 1ns/1ps
module evt_thr_detect_tb_top;
  localparam int KEY_W = 8;
  localparam int IDX_W = 4;
  localparam int CNT_W = 8;
  localparam int WIN_W = 16;
  localparam int ENT   = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             evt = 1'b0;
  logic [KEY_W-1:0] key = '0;
  logic [CNT_W-1:0] thresh = CNT_W'(1);
  logic [WIN_W-1:0] win = WIN_W'(10);
  logic             fire;
  logic [KEY_W-1:0] fire_key;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  bit             m_vld [ENT];
  logic [KEY_W-1:0] m_tag [ENT];
  int             m_cnt [ENT];
  int             m_start [ENT];

  always #10 clk = ~clk;

  evt_thr_detect #(
    .KEY_W(KEY_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .WIN_W(WIN_W)
  ) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .key_i     (key),
    .thresh_i  (thresh),
    .win_len_i (win),
    .fire_o    (fire),
    .fire_key_o(fire_key)
  );

  task automatic model_clear();
    for (int i = 0; i < ENT; i++) begin
      m_vld[i] = 0; m_cnt[i] = 0; m_start[i] = 0; m_tag[i] = '0;
    end
  endtask

  task automatic model_event(input logic [KEY_W-1:0] k, output bit f);
    int  i;
    int  thr;
    int  n;
    bit  fresh;
    i   = int'(k[IDX_W-1:0]);
    thr = (thresh == 0) ? 1 : int'(thresh);
    fresh = !m_vld[i] || (m_tag[i] != k) || ((cyc - m_start[i]) >= int'(win));
    n = fresh ? 1 : m_cnt[i] + 1;
    if (n >= thr) begin
      f = 1; m_vld[i] = 0; m_cnt[i] = 0;
    end else begin
      f = 0; m_vld[i] = 1; m_tag[i] = k; m_cnt[i] = n;
      if (fresh) m_start[i] = cyc;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // drive at negedge, the next posedge samples, check at the following negedge
  task automatic step(input bit e, input logic [KEY_W-1:0] k, input string req);
    bit f;
    f = 0;
    evt = e;
    key = k;
    if (e) model_event(k, f);
    cyc++;
    @(negedge clk);
    if (f) begin
      check(fire === 1'b1, req, int'(fire), 1);
      check(fire_key === k, req, int'(fire_key), int'(k));
    end else begin
      check(fire === 1'b0, req, int'(fire), 0);
    end
  endtask

  task automatic idle(input int n, input string req);
    for (int j = 0; j < n; j++) step(0, '0, req);
  endtask

  task automatic do_reset();
    evt = 0;
    rst_ni = 0;
    model_clear();
    @(negedge clk); cyc++;
    @(negedge clk); cyc++;
    check(fire === 1'b0, "R1", int'(fire), 0);
    rst_ni = 1;
    @(negedge clk); cyc++;
    check(fire === 1'b0, "R1", int'(fire), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    // R2: unit and zero thresholds fire on each event
    thresh = 1; win = 10;
    step(1, 8'h05, "R2"); step(1, 8'h05, "R2"); step(1, 8'h17, "R2");
    thresh = 0;
    step(1, 8'h05, "R2"); idle(1, "R8"); step(1, 8'h2a, "R2");

    // R3: threshold 3, fire only on third
    thresh = 3; win = 20;
    step(1, 8'h41, "R3"); idle(1, "R3"); step(1, 8'h41, "R3"); idle(2, "R3");
    step(1, 8'h41, "R3"); idle(1, "R8");

    // R7: after fire next event is a fresh run
    step(1, 8'h41, "R7"); step(1, 8'h41, "R7"); step(1, 8'h41, "R7");

    // R4: window boundary, threshold 2, window 10
    do_reset();
    thresh = 2; win = 10;
    step(1, 8'h31, "R4"); idle(8, "R4"); step(1, 8'h31, "R4");
    step(1, 8'h31, "R4"); idle(9, "R4"); step(1, 8'h31, "R4");
    step(1, 8'h31, "R4");

    // R5: different slots do not add
    step(1, 8'h11, "R5"); step(1, 8'h12, "R5"); step(1, 8'h13, "R5");
    step(1, 8'h12, "R5"); step(1, 8'h11, "R5"); step(1, 8'h13, "R5");

    // R6: same slot, different tag replaces
    step(1, 8'h1c, "R6"); step(1, 8'h2c, "R6"); step(1, 8'h1c, "R6");
    step(1, 8'h1c, "R6");

    // R1: reset mid-run discards the partial count
    step(1, 8'h77, "R1");
    do_reset();
    step(1, 8'h77, "R1"); step(1, 8'h77, "R1");

    // constrained random mix
    for (int r = 0; r < 1500; r++) begin
      logic [KEY_W-1:0] k;
      if (r % 50 == 0) begin
        thresh = CNT_W'(($urandom % 4) + 1);
        win    = WIN_W'(($urandom % 18) + 2);
      end
      k = (($urandom % 2) != 0) ? 8'h10 : 8'h20;
      k = k | KEY_W'($urandom % 4);
      step(($urandom % 10) < 6, k, "R3");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule